// File: doc/BRIEF.md
# Launch Time Transmit Gate

This block sits in front of a transmit path and holds queued frame descriptors until their scheduled moment. Each descriptor carries a frame tag and a launch time. The launch time gives only the position inside the current second. The block compares it with a free-running local time counter, which also counts nanoseconds within one second and wraps at the period. A frame is released to the transmit path when the counter reaches its launch time and the path signals ready.

Because the launch time wraps every second, the block decides which second it means when the descriptor arrives. It measures the forward distance from the current time to the launch time, modulo the period. A short forward distance means the frame is held. A distance past the half-period point means the moment has already passed: the frame is late, goes out at the first chance, and carries a late flag. Distances between a configurable ahead limit and the half-period mark are ambiguous, because they could alias to the wrong second. Such a frame also goes out at once, with a too-far flag, so the host can discard it. Frames leave strictly in queue order. A typical launch time is a receive timestamp plus a fixed delay, and that delay must exceed the worst-case processing time so the frame is not late.

Top module: `launch_gate`

## Requirements
- R1: With ahead = (launch - time) mod PERIOD measured at enqueue, a descriptor with 1 <= ahead <= AHEAD_LIMIT is released, with both flags low, in the first cycle where (time - launch) mod PERIOD < PERIOD/2, that is when the counter reaches the launch time, including across the wrap from PERIOD-1 to 0.
- R2: relValid is asserted only in a cycle where txReady is high. While txReady is low, a frame that is due stays queued.
- R3: A descriptor with ahead > PERIOD/2 is late: it is released as soon as it is at the head and the path is ready, with relLate=1 and relFar=0.
- R4: A descriptor with AHEAD_LIMIT < ahead <= PERIOD/2 is released as soon as possible with relFar=1 and relLate=0. relLate and relFar are never both high.
- R5: A descriptor with ahead = 0 is released as soon as possible with both flags low.
- R6: Frames are released in enqueue order. A due frame behind a held frame waits until the held frame has been released.
- R7: The queue holds DEPTH descriptors. When it is full, enqReady is low and an enqueue attempt is ignored. No extra frame is released later.
- R8: A synchronous reset empties the queue. In the cycle after reset, relValid is low and enqReady is high, and no descriptor that was queued before the reset is ever released.
- R9: relValid is a one-cycle strobe for each frame. A released frame is removed, and the queue count changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enqValid | input | 1 | Descriptor offered |
| enqLaunch | input | TIME_W | Launch time within the second (0 to PERIOD-1) |
| enqTag | input | TAG_W | Frame tag |
| enqReady | output | 1 | Queue can accept a descriptor |
| curTime | input | TIME_W | Local time counter within the second |
| txReady | input | 1 | Transmit path can take a frame |
| relValid | output | 1 | Release strobe |
| relTag | output | TAG_W | Tag of the released frame |
| relLate | output | 1 | Released frame arrived after its launch time |
| relFar | output | 1 | Released frame was too far ahead to place reliably |

## Verification
A descriptor is written at the clock edge that accepts it and reaches the head one cycle later. The release strobe is combinational from the head entry, the time input and txReady. Measured in falling edges after the accepting edge, a frame that is late, too far ahead or due at once appears at the first falling edge. A held frame with forward distance k appears at the k-th falling edge. The bench drives a time counter that advances by one per cycle. It sweeps every forward distance over a small period and counts falling edges until the strobe, comparing the count with these figures. The same cycle arithmetic fixes the expected edges in the ordering, back-pressure, full-queue and reset scenarios.

// File: rtl/launch_gate_pkg.sv
package launch_gate_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic push;
    logic pop;
  } gateStrobes_t;

endpackage

// File: rtl/launch_gate_dp.sv
module launch_gate_dp
  import launch_gate_pkg::*;
#(
  parameter int TIME_W      = 30,
  parameter int PERIOD      = 1000000000,
  parameter int AHEAD_LIMIT = PERIOD / 2 - 1,
  parameter int TAG_W       = 8,
  parameter int DEPTH       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  gateStrobes_t      strb,
  input  logic [TIME_W-1:0] enqLaunch,
  input  logic [TAG_W-1:0]  enqTag,
  input  logic [TIME_W-1:0] curTime,
  output logic [TAG_W-1:0]  headTag,
  output logic              headLate,
  output logic              headFar,
  output logic              headGo
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int XW    = TIME_W + 1;
  localparam logic [XW-1:0] PER_X  = XW'(PERIOD);
  localparam logic [XW-1:0] HALF_X = XW'(PERIOD / 2);
  localparam logic [XW-1:0] LIM_X  = XW'(AHEAD_LIMIT);

  // forward distance from b to a, modulo the period
  function automatic logic [XW-1:0] modDist(input logic [TIME_W-1:0] a,
                                            input logic [TIME_W-1:0] b);
    logic [XW-1:0] ax;
    logic [XW-1:0] bx;
    ax = {1'b0, a};
    bx = {1'b0, b};
    if (ax >= bx) return ax - bx;
    else          return ax + PER_X - bx;
  endfunction

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    else                        return p + 1'b1;
  endfunction

  // classification at enqueue
  logic [XW-1:0] aheadAtEnq;
  logic          enqLate;
  logic          enqFar;

  always_comb begin
    aheadAtEnq = modDist(enqLaunch, curTime);
    enqLate    = (aheadAtEnq > HALF_X);
    enqFar     = (aheadAtEnq > LIM_X) && !enqLate;
  end

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  // per-entry storage
  logic [TIME_W-1:0] launchMem [DEPTH];
  logic [TAG_W-1:0]  tagMem    [DEPTH];
  logic              lateMem   [DEPTH];
  logic              farMem    [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic wrHere;
    assign wrHere = strb.push && (wrPtr == PTR_W'(e));
    always_ff @(posedge clk) begin
      if (rst) begin
        launchMem[e] <= '0;
        tagMem[e]    <= '0;
        lateMem[e]   <= 1'b0;
        farMem[e]    <= 1'b0;
      end else if (wrHere) begin
        launchMem[e] <= enqLaunch;
        tagMem[e]    <= enqTag;
        lateMem[e]   <= enqLate;
        farMem[e]    <= enqFar;
      end
    end
  end

  // head eligibility
  logic [XW-1:0] headSince;

  always_comb begin
    headSince = modDist(curTime, launchMem[rdPtr]);
    headTag   = tagMem[rdPtr];
    headLate  = lateMem[rdPtr];
    headFar   = farMem[rdPtr];
    headGo    = headLate || headFar || (headSince < HALF_X);
  end

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lateMem[rdPtr], farMem[rdPtr]})); // R4

endmodule

// File: rtl/launch_gate_ctrl.sv
module launch_gate_ctrl
  import launch_gate_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enqValid,
  input  logic         txReady,
  input  logic         headGo,
  output logic         enqReady,
  output logic         relValid,
  output gateStrobes_t strb
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic             nonEmpty;

  always_comb begin
    nonEmpty  = (count != '0);
    enqReady  = (count < FULL_CNT);
    strb.push = enqValid && enqReady;
    strb.pop  = nonEmpty && headGo && txReady;
    relValid  = strb.pop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R7

  AST_REL_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    relValid |-> txReady); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((count == $past(count)) || (count == $past(count) + 1'b1)
                     || (count == $past(count) - 1'b1))); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (count == '0)); // R8

endmodule

// File: rtl/launch_gate.sv
module launch_gate
  import launch_gate_pkg::*;
#(
  parameter int TIME_W      = 30,
  parameter int PERIOD      = 1000000000,
  parameter int AHEAD_LIMIT = PERIOD / 2 - 1,
  parameter int TAG_W       = 8,
  parameter int DEPTH       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enqValid,
  input  logic [TIME_W-1:0] enqLaunch,
  input  logic [TAG_W-1:0]  enqTag,
  output logic              enqReady,
  input  logic [TIME_W-1:0] curTime,
  input  logic              txReady,
  output logic              relValid,
  output logic [TAG_W-1:0]  relTag,
  output logic              relLate,
  output logic              relFar
);

  gateStrobes_t     strb;
  logic             headGo;
  logic             headLate;
  logic             headFar;
  logic [TAG_W-1:0] headTag;

  launch_gate_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enqValid (enqValid),
    .txReady  (txReady),
    .headGo   (headGo),
    .enqReady (enqReady),
    .relValid (relValid),
    .strb     (strb)
  );

  launch_gate_dp #(
    .TIME_W      (TIME_W),
    .PERIOD      (PERIOD),
    .AHEAD_LIMIT (AHEAD_LIMIT),
    .TAG_W       (TAG_W),
    .DEPTH       (DEPTH)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .enqLaunch (enqLaunch),
    .enqTag    (enqTag),
    .curTime   (curTime),
    .headTag   (headTag),
    .headLate  (headLate),
    .headFar   (headFar),
    .headGo    (headGo)
  );

  assign relTag  = relValid ? headTag : '0;
  assign relLate = relValid && headLate;
  assign relFar  = relValid && headFar;

  AST_FLAGS_ONLY_ON_REL: assert property (@(posedge clk) disable iff (rst)
    (relLate || relFar) |-> relValid); // R4

endmodule

// File: tb/launch_gate_bench.sv
module launch_gate_bench;

  localparam int TW    = 6;
  localparam int P     = 50;
  localparam int HALF  = P / 2;
  localparam int LIM   = 20;
  localparam int TAGW  = 8;
  localparam int DEPTH = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            enqValid = 1'b0;
  logic [TW-1:0]   enqLaunch = '0;
  logic [TAGW-1:0] enqTag = '0;
  logic            enqReady;
  logic [TW-1:0]   curTime = TW'(37);
  logic            txReady = 1'b1;
  logic            relValid;
  logic [TAGW-1:0] relTag;
  logic            relLate;
  logic            relFar;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // free-running local time, independent of the gate reset
  always_ff @(posedge clk) begin
    curTime <= (curTime == TW'(P - 1)) ? '0 : curTime + 1'b1;
    cyc     <= cyc + 1;
  end

  launch_gate #(.TIME_W(TW), .PERIOD(P), .AHEAD_LIMIT(LIM),
                .TAG_W(TAGW), .DEPTH(DEPTH)) u_launch_gate (
    .clk(clk), .rst(rst), .enqValid(enqValid), .enqLaunch(enqLaunch),
    .enqTag(enqTag), .enqReady(enqReady), .curTime(curTime),
    .txReady(txReady), .relValid(relValid), .relTag(relTag),
    .relLate(relLate), .relFar(relFar)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // offer one descriptor at the next falling edge; returns cycle index of accept
  task automatic push(input int k, input int tag, output int acc);
    @(negedge clk);
    enqValid  = 1'b1;
    enqLaunch = TW'((int'(curTime) + k) % P);
    enqTag    = TAGW'(tag);
    @(posedge clk);
    #1;
    enqValid = 1'b0;
    acc = cyc;
  endtask

  task automatic sweepOne(input int k);
    int acc;
    int n;
    int expN;
    bit expLate;
    bit expFar;
    push(k, k, acc);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      n++;
      if (relValid) break;
    end
    expLate = (k > HALF);
    expFar  = (k > LIM) && !expLate;
    expN    = (expLate || expFar || k == 0) ? 1 : k;
    if (expLate)     check(n == expN, "R3 late timing", n, expN);
    else if (expFar) check(n == expN, "R4 far timing", n, expN);
    else if (k == 0) check(n == expN, "R5 due-now timing", n, expN);
    else             check(n == expN, "R1 held release cycle", n, expN);
    check(relTag == TAGW'(k), "R1 tag", relTag, k);
    check(relLate == expLate, "R3 late flag", relLate, expLate);
    check(relFar == expFar, "R4 far flag", relFar, expFar);
    @(negedge clk);
    check(!relValid, "R9 single strobe", relValid, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int acc;
    int rel1;
    int rel2;
    int nrel;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(enqReady == 1'b1, "R8 reset enqReady", enqReady, 1);
    check(relValid == 1'b0, "R8 reset relValid", relValid, 0);

    // exhaustive sweep of forward distances, two passes to cover the wrap
    for (int pass = 0; pass < 2; pass++)
      for (int k = 0; k < P; k++) sweepOne(k);

    // R6 ordering: held frame ahead of an already-due one
    push(10, 8'hA1, acc);
    push(3, 8'hB2, rel1);
    rel1 = -1;
    rel2 = -1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (relValid && relTag == 8'hA1) rel1 = cyc;
      if (relValid && relTag == 8'hB2) rel2 = cyc;
    end
    check(rel1 == acc + 9, "R6 first frame cycle", rel1 - acc, 9);
    check(rel2 == acc + 10, "R6 second frame waits", rel2 - acc, 10);

    // R7 full queue: five offers, four accepted
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (i == 5) check(enqReady == 1'b0, "R7 full enqReady", enqReady, 0);
      enqValid  = 1'b1;
      enqLaunch = TW'((int'(curTime) + LIM) % P);
      enqTag    = TAGW'(i);
      @(posedge clk);
      #1;
      enqValid = 1'b0;
    end
    nrel = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (relValid) begin
        nrel++;
        check(relTag == TAGW'(nrel), "R7 order of kept frames", relTag, nrel);
      end
    end
    check(nrel == 4, "R7 extra offer ignored", nrel, 4);

    // R2 back-pressure
    txReady = 1'b0;
    push(40, 8'h77, acc);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!relValid, "R2 hold while not ready", relValid, 0);
    end
    txReady = 1'b1;
    #1;
    check(relValid && relTag == 8'h77, "R2 release on ready", relTag, 8'h77);
    check(relLate == 1'b1, "R3 late after back-pressure", relLate, 1);
    @(negedge clk);
    check(!relValid, "R9 strobe one cycle", relValid, 0);

    // R8 reset empties queue
    push(15, 8'h55, acc);
    push(15, 8'h56, acc);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(enqReady == 1'b1, "R8 enqReady after reset", enqReady, 1);
    check(!relValid, "R8 relValid after reset", relValid, 0);
    nrel = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (relValid) nrel++;
    end
    check(nrel == 0, "R8 no stale release", nrel, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule